// File: doc/BRIEF.md
# Spread Spectrum Modulation Controller

This block generates the frequency-offset sweep that steers the fractional feedback divider of a spread-spectrum clock PLL. It runs on the reference clock. It produces a signed offset word in units of 0.01 percent of the nominal frequency, and the word follows a triangle centred on zero. One modulation period lasts 2332 reference cycles, whatever setting is chosen. The modulation rate is therefore the reference frequency divided by 2332.

Two three-level selection inputs choose the spread. Each is given as a 2-bit code, and together they give nine settings. Five settings belong to the lower input-frequency range and four to the upper range. A band-index input picks the row of the amplitude table that matches the actual reference frequency. The chosen peak-to-peak spread is halved to give the triangle's peak. Selection and band changes take effect only at the start of a modulation period. Dropping the enable input parks the sweep at the next zero crossing, so the output frequency never jumps.

The enable pin is meant to be tied high by default in the integration, so after reset the sweep starts as soon as enable is sampled high.

Top module: `ssm_ctrl`

## Requirements
- R1: Each selection code means 2'b00 = low, 2'b01 = middle, 2'b10 = high. The invalid code 2'b11 is treated exactly as middle.
- R2: In the lower range, written as (first, second) selection, the settings are MM, M0, 10, 00 and 0M, in decreasing spread. With band index 0 their peak-to-peak spreads are 430, 390, 330, 290 and 270 (in 0.01 %).
- R3: In the upper range the settings are 1M, 01, 11 and M1, in decreasing spread. With band index 0 their spreads are 300, 240, 150 and 130.
- R4: The band index picks the table row. Lower-range rows are 0..3, and any index of 3 or more uses row 3 (for example M0 at row 3 gives 310 and MM at row 3 gives 350). Upper-range rows are 0..4, and any index of 4 or more uses row 4 (for example 1M at row 2 gives 260 and M1 at row 4 gives 100).
- R5: Let A be half the spread, Q = 583 and P = 2332. The offset k cycles after the sweep starts has phase p = k mod P, quarter q = p / Q, t = p mod Q and s = floor(t*A/Q). Its value is s for q=0, A-s for q=1, -s for q=2 and s-A for q=3.
- R6: The offset changes by at most one unit per cycle. It reaches +A at phase 583 and -A at phase 1749, and its magnitude never exceeds A.
- R7: While enable is low and the sweep is parked, the offset is 0. The first rising edge with enable high starts the sweep at k = 0, and k advances by one each cycle after that.
- R8: When enable goes low during a sweep, the profile continues unchanged until the next zero point (phase 0 or phase 1166). The offset then stays 0.
- R9: A change of selection or band during a period does not alter that period. The new amplitude applies from the next period start.
- R10: During reset and right after it, the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spread_en | input | 1 | High runs the sweep, low parks it at the next zero point |
| sel_first | input | 2 | First three-level selection code |
| sel_second | input | 2 | Second three-level selection code |
| band_idx | input | 3 | Reference-frequency band row |
| offset_o | output | 10 | Signed frequency offset in 0.01 % units |

## Verification
The assertions assume that the selection, band and enable inputs are synchronous to the reference clock. They also assume that every table entry is no more than twice the quarter length, so that at most one offset step is due per cycle. The stimulus changes inputs only one time unit after a rising edge. All its table values stay far below that limit, including the clamped band indices and the invalid selection code.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

   typedef enum logic [1:0] {
      LVL_LO  = 2'd0,
      LVL_MID = 2'd1,
      LVL_HI  = 2'd2
   } lvl_t;

   localparam int LO_COLS = 5;
   localparam int HI_COLS = 4;
   localparam int LO_ROWS = 4;
   localparam int HI_ROWS = 5;

   // code 2'b11 is invalid and folds onto the middle level
   function automatic lvl_t code_to_lvl(input logic [1:0] code);
      case (code)
         2'b00:   code_to_lvl = LVL_LO;
         2'b10:   code_to_lvl = LVL_HI;
         default: code_to_lvl = LVL_MID;
      endcase
   endfunction

endpackage

// File: rtl/ssm_sel_decode.sv
module ssm_sel_decode
   import ssm_pkg::*;
(
   input  logic [1:0] code_first,
   input  logic [1:0] code_second,
   output logic       hi_range,
   output logic [2:0] column
);

   logic [1:0] codes [2];
   lvl_t       lvl   [2];

   assign codes[0] = code_first;
   assign codes[1] = code_second;

   for (genvar gi = 0; gi < 2; gi++) begin : g_lvl
      assign lvl[gi] = code_to_lvl(codes[gi]);
   end

   always_comb begin
      hi_range = 1'b0;
      column   = 3'd0;
      unique case ({lvl[0], lvl[1]})
         {LVL_MID, LVL_MID}: begin hi_range = 1'b0; column = 3'd0; end
         {LVL_MID, LVL_LO }: begin hi_range = 1'b0; column = 3'd1; end
         {LVL_HI,  LVL_LO }: begin hi_range = 1'b0; column = 3'd2; end
         {LVL_LO,  LVL_LO }: begin hi_range = 1'b0; column = 3'd3; end
         {LVL_LO,  LVL_MID}: begin hi_range = 1'b0; column = 3'd4; end
         {LVL_HI,  LVL_MID}: begin hi_range = 1'b1; column = 3'd0; end
         {LVL_LO,  LVL_HI }: begin hi_range = 1'b1; column = 3'd1; end
         {LVL_HI,  LVL_HI }: begin hi_range = 1'b1; column = 3'd2; end
         {LVL_MID, LVL_HI }: begin hi_range = 1'b1; column = 3'd3; end
         default:            begin hi_range = 1'b0; column = 3'd0; end
      endcase
   end

   // R2 R3: the column always fits the range it indexes
   always_comb begin
      a_col_range_r2: assert (hi_range ? (column < 3'(HI_COLS)) : (column < 3'(LO_COLS)))
         else $error("decoded column out of range");
   end

endmodule

// File: rtl/ssm_amp_table.sv
module ssm_amp_table
   import ssm_pkg::*;
#(
   parameter int BAND_W  = 3,
   parameter int AMP_W   = 9,
   parameter bit REG_OUT = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_range,
   input  logic [2:0]        column,
   input  logic [BAND_W-1:0] band,
   output logic [AMP_W-1:0]  ptp
);

   localparam int LO_N = LO_ROWS * LO_COLS;
   localparam int HI_N = HI_ROWS * HI_COLS;

   // peak-to-peak spread in 0.01 % units, row-major
   localparam int LO_TBL [LO_N] = '{
      430, 390, 330, 290, 270,
      400, 360, 310, 260, 250,
      380, 340, 290, 250, 240,
      350, 310, 270, 220, 210 };
   localparam int HI_TBL [HI_N] = '{
      300, 240, 150, 130,
      270, 210, 140, 110,
      260, 200, 130, 110,
      260, 200, 130, 110,
      250, 180, 120, 100 };

   if (BAND_W < 3) begin : g_bad_band
      $error("BAND_W must cover all upper-range rows");
   end
   if (AMP_W < 9) begin : g_bad_amp
      $error("AMP_W too narrow for the largest spread");
   end

   int row;
   int idx;
   logic [AMP_W-1:0] ptp_c;

   always_comb begin
      if (hi_range)
         row = (int'(band) >= HI_ROWS) ? HI_ROWS - 1 : int'(band);
      else
         row = (int'(band) >= LO_ROWS) ? LO_ROWS - 1 : int'(band);
      if (hi_range) begin
         idx   = row * HI_COLS + int'(column);
         ptp_c = (idx < HI_N) ? AMP_W'(HI_TBL[idx]) : '0;
      end else begin
         idx   = row * LO_COLS + int'(column);
         ptp_c = (idx < LO_N) ? AMP_W'(LO_TBL[idx]) : '0;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptp <= '0;
         else        ptp <= ptp_c;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign ptp = ptp_c;
   end

endmodule

// File: rtl/ssm_tri_gen.sv
module ssm_tri_gen #(
   parameter int PERIOD    = 2332,
   parameter int AMP_W     = 9,
   parameter int OFS_W     = 10,
   parameter int MAX_PEAK  = 215
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [AMP_W-1:0]        peak_in,
   output logic signed [OFS_W-1:0] offset
);

   localparam int Q    = PERIOD / 4;
   localparam int QCW  = $clog2(Q);
   localparam int EW   = QCW + 1;
   localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

   if (PERIOD % 4 != 0) begin : g_bad_period
      $error("PERIOD must split into four equal quarters");
   end
   if (MAX_PEAK > Q) begin : g_bad_peak
      $error("peak above quarter length would need two steps per cycle");
   end
   if (OFS_W <= AMP_W) begin : g_bad_ofs
      $error("OFS_W must exceed AMP_W to hold signed peaks");
   end
   if (AMP_W > EW) begin : g_bad_err
      $error("error accumulator narrower than amplitude");
   end

   logic                    run;
   logic [1:0]              qi;
   logic [QCW-1:0]          qc;
   logic [EW-1:0]           err;
   logic [AMP_W-1:0]        amp_r;
   logic signed [OFS_W-1:0] ofs;

   logic          at_zero, wrap_q, per_end, rising, step;
   logic [EW-1:0] err_sum, err_n;

   always_comb begin
      at_zero = (qc == '0) && !qi[0];
      wrap_q  = (qc == QCW'(Q - 1));
      per_end = wrap_q && (qi == 2'd3);
      rising  = (qi == 2'd0) || (qi == 2'd3);
      err_sum = err + EW'(amp_r);
      step    = (err_sum >= EW'(Q));
      err_n   = step ? err_sum - EW'(Q) : err_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         qi    <= '0;
         qc    <= '0;
         err   <= '0;
         amp_r <= '0;
         ofs   <= '0;
      end else if (!run || (!en && at_zero)) begin
         run   <= run ? 1'b0 : en;
         qi    <= '0;
         qc    <= '0;
         err   <= '0;
         ofs   <= '0;
         amp_r <= peak_in;
      end else begin
         qc  <= wrap_q ? '0 : qc + 1'b1;
         if (wrap_q) qi <= qi + 2'd1;
         err <= err_n;
         if (step) ofs <= rising ? ofs + ONE : ofs - ONE;
         if (per_end) amp_r <= peak_in;
      end
   end

   assign offset = ofs;

   logic signed [OFS_W-1:0] amp_s;
   assign amp_s = OFS_W'(amp_r);

   p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs <= amp_s) && (ofs >= -amp_s));

   p_slew_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (ofs == $past(ofs)) || (ofs == $past(ofs) + ONE) || (ofs == $past(ofs) - ONE));

   p_quarter_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && qc == '0) |-> (err == '0));

   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (ofs == '0));

   p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> ($past(ofs) == '0));

   p_amp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !per_end && !(!en && at_zero)) |=> $stable(amp_r));

endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl #(
   parameter int PERIOD   = 2332,
   parameter int BAND_W   = 3,
   parameter int AMP_W    = 9,
   parameter int OFS_W    = 10,
   parameter bit REG_LUT  = 1'b0
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    spread_en,
   input  logic [1:0]              sel_first,
   input  logic [1:0]              sel_second,
   input  logic [BAND_W-1:0]       band_idx,
   output logic signed [OFS_W-1:0] offset_o
);

   localparam int MAX_PEAK = 215;

   logic             hi_range;
   logic [2:0]       column;
   logic [AMP_W-1:0] ptp;
   logic [AMP_W-1:0] peak;

   ssm_sel_decode u_dec (
      .code_first  (sel_first),
      .code_second (sel_second),
      .hi_range    (hi_range),
      .column      (column)
   );

   ssm_amp_table #(
      .BAND_W  (BAND_W),
      .AMP_W   (AMP_W),
      .REG_OUT (REG_LUT)
   ) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_range (hi_range),
      .column   (column),
      .band     (band_idx),
      .ptp      (ptp)
   );

   assign peak = ptp >> 1;

   ssm_tri_gen #(
      .PERIOD   (PERIOD),
      .AMP_W    (AMP_W),
      .OFS_W    (OFS_W),
      .MAX_PEAK (MAX_PEAK)
   ) u_tri (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (spread_en),
      .peak_in (peak),
      .offset  (offset_o)
   );

   p_reset_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (offset_o == '0));

endmodule

// File: tb/sim_ssm_ctrl.sv
`timescale 1ns/1ps
module sim_ssm_ctrl;

   localparam int P = 2332;
   localparam int Q = 583;
   localparam int NV = 14;

   // {first, second, band, ptp}
   localparam logic [15:0] VEC [NV] = '{
      {2'b01, 2'b01, 3'd0, 9'd430},   // R2 MM
      {2'b01, 2'b00, 3'd0, 9'd390},   // R2 M0
      {2'b10, 2'b00, 3'd0, 9'd330},   // R2 10
      {2'b00, 2'b00, 3'd0, 9'd290},   // R2 00
      {2'b00, 2'b01, 3'd0, 9'd270},   // R2 0M
      {2'b10, 2'b01, 3'd0, 9'd300},   // R3 1M
      {2'b00, 2'b10, 3'd0, 9'd240},   // R3 01
      {2'b10, 2'b10, 3'd0, 9'd150},   // R3 11
      {2'b01, 2'b10, 3'd0, 9'd130},   // R3 M1
      {2'b01, 2'b00, 3'd3, 9'd310},   // R4 M0 row 3
      {2'b01, 2'b01, 3'd4, 9'd350},   // R4 MM clamped
      {2'b11, 2'b00, 3'd0, 9'd390},   // R1 invalid code as M
      {2'b01, 2'b10, 3'd7, 9'd100},   // R4 M1 clamped
      {2'b10, 2'b01, 3'd2, 9'd260}    // R4 1M row 2
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic [1:0]        sa = 2'b01;
   logic [1:0]        sb = 2'b01;
   logic [2:0]        band = 3'd0;
   logic signed [9:0] ofs;

   int checks = 0;
   int fails = 0;
   int k = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ssm_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .spread_en  (en),
      .sel_first  (sa),
      .sel_second (sb),
      .band_idx   (band),
      .offset_o   (ofs)
   );

   function automatic int expf(int kk, int a);
      int p, q, t, s;
      p = kk % P;
      q = p / Q;
      t = p % Q;
      s = (t * a) / Q;
      case (q)
         0: return s;
         1: return a - s;
         2: return -s;
         default: return s - a;
      endcase
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
      k++;
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // park, wait for idle, then raise enable; returns with k = 0 at start edge
   task automatic start_sweep();
      en = 1'b0;
      repeat (P / 2 + 4) step();
      en = 1'b1;
      @(posedge clk);
      #1;
      k = 0;
   endtask

   initial begin
      #(150000 * 10);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int a;
      int bad;
      // R10 reset state
      #12;
      chk("R10 in reset", int'(ofs), 0);
      rst_n = 1'b1;
      repeat (3) step();
      chk("R10 after reset", int'(ofs), 0);
      chk("R7 parked while low", int'(ofs), 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         sa   = VEC[v][15:14];
         sb   = VEC[v][13:12];
         band = VEC[v][11:9];
         a    = int'(VEC[v][8:0]) / 2;
         start_sweep();
         chk("R7 start value", int'(ofs), 0);
         bad = 0;
         for (int i = 1; i <= P; i++) begin
            step();
            if (k == Q) chk("R6 positive peak", int'(ofs), a);
            if (k == 3 * Q) chk("R6 negative peak", int'(ofs), -a);
            if (int'(ofs) != expf(k, a)) bad++;
         end
         chk($sformatf("R5 profile vector %0d mismatches", v), bad, 0);
      end

      // R8 disable mid-sweep
      sa = 2'b01; sb = 2'b01; band = 3'd0; a = 215;
      start_sweep();
      while (k < 700) step();
      en = 1'b0;
      while (k < 1100) step();
      chk("R8 continues after enable low", int'(ofs), expf(1100, a));
      while (k < 1166) step();
      chk("R8 zero point reached", int'(ofs), 0);
      while (k < 1300) step();
      chk("R8 parked after zero", int'(ofs), 0);
      while (k < 2000) step();
      chk("R8 stays parked", int'(ofs), 0);

      // R9 change mid-period
      start_sweep();
      while (k < 100) step();
      sa = 2'b00; sb = 2'b00; band = 3'd2;   // 00 row 2 -> 250
      while (k < Q) step();
      chk("R9 old amplitude holds", int'(ofs), 215);
      while (k < P + Q) step();
      chk("R9 new amplitude positive", int'(ofs), 125);
      while (k < P + 3 * Q) step();
      chk("R9 new amplitude negative", int'(ofs), -125);
      en = 1'b0;
      repeat (P) step();
      chk("R7 parked again", int'(ofs), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule